// File: doc/BRIEF.md
# Missing-Energy Significance Threshold Stage

This block decides, against eight programmable thresholds, whether a missing-energy magnitude is large compared with the square root of the total scalar energy. Division and square root are not computed. Two chained table lookups replace them. The first table turns the 12-bit scalar energy into a 6-bit square-root code. The second table is addressed by that code and by a 6-bit compressed magnitude, and it returns eight hit bits. Each hit bit says that the ratio passed one threshold.

The magnitude arrives as a 7-bit value plus a 2-bit range code. A compressor squeezes it to 6 bits in one of two ways. The full-precision mode keeps the low bits. The half-precision mode drops the LSB, which doubles the reach. Any value that does not fit becomes the all-ones code, so out-of-range conditions travel through the stage as saturated data and not as flags. The tables are filled through a host port that can also read them back.

Samples move through two registered stages. The first stage does the square-root lookup and the compression side by side. The second stage does the ratio lookup. Latency is a fixed two cycles, and a new sample can be accepted on every cycle.

Top module: `miss_sig_stage`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o`, `hits_o` and `host_rdata_o` are all zero until a sample or a host read produces data.
- R2: A sample presented with `in_valid_i` high at clock edge k produces `valid_o` high after edge k+2. A sample is accepted on every cycle. `valid_o` is never high two edges after an edge where `in_valid_i` was low.
- R3: The square-root table is addressed by `energy_i`. Its 6-bit entry is the low 6 bits of the ratio-table address.
- R4: In full-precision mode (`mode_i` = 0), the compressed magnitude is `miss_val_i[5:0]`. If `miss_val_i[6]` is set, it is 63 instead.
- R5: In half-precision mode (`mode_i` = 1), the compressed magnitude is `miss_val_i[6:1]`.
- R6: `hits_o` is the ratio-table entry at address compressed_magnitude*64 + root_code. Each bit t is the result for threshold t.
- R7: The mode is taken from `mode_i` only at clock edges where neither pipeline stage holds a sample. A change of `mode_i` while samples are in flight has no effect on those samples or on samples that follow them back to back.
- R8: When `host_we_i` is high, `host_wdata_i` is written at `host_addr_i` into one table. `host_sel_i` = 0 selects the square-root table, which keeps the low 6 bits. `host_sel_i` = 1 selects the ratio table, which keeps all 8 bits.
- R9: One cycle after `host_addr_i` and `host_sel_i` are presented, `host_rdata_o` holds the addressed entry. For the square-root table, bits 7:6 read as zero.
- R10: In both modes, a nonzero `miss_rng_i` forces the compressed magnitude to 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Sample present |
| energy_i | input | 12 | Total scalar energy |
| miss_val_i | input | 7 | Missing-energy value bits |
| miss_rng_i | input | 2 | Missing-energy range code |
| mode_i | input | 1 | 0 full precision, 1 half precision |
| valid_o | output | 1 | Hit bits valid |
| hits_o | output | 8 | Threshold hit bits |
| host_we_i | input | 1 | Table write strobe |
| host_sel_i | input | 1 | 0 square-root table, 1 ratio table |
| host_addr_i | input | 12 | Table address |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data, one cycle after address |

## Verification
The assertions assume three things about the inputs. The tables are not written while samples are in flight. `mode_i` is only expected to take effect after the pipeline has drained. The host reads only the table that is currently selected. The stimulus follows these rules. It loads both tables completely before any sample is sent. It changes the mode only during idle gaps of at least three cycles, except in one deliberate case where the mode is switched in the middle of a back-to-back burst. The samples cover both mode encodings, every range code, the value boundaries 63, 64 and 127, odd values in half-precision mode, and energies of 0 and 4095.

// File: rtl/miss_sig_pkg.sv
package miss_sig_pkg;
  typedef enum logic {
    CMP_FULL = 1'b0,
    CMP_HALF = 1'b1
  } cmp_mode_e;

  typedef enum logic {
    TBL_ROOT  = 1'b0,
    TBL_RATIO = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/sig_compress.sv
module sig_compress
  import miss_sig_pkg::*;
#(
  parameter int V_W = 7,
  parameter int R_W = 2,
  parameter int M_W = 6
) (
  input  cmp_mode_e        mode_i,
  input  logic [V_W-1:0]   val_i,
  input  logic [R_W-1:0]   rng_i,
  output logic [M_W-1:0]   mag_o
);
  localparam int HALF_HI = V_W - M_W - 1;

  logic full_over, half_over, half_top;

  assign full_over = (|val_i[V_W-1:M_W]) | (|rng_i);

  generate
    if (HALF_HI > 0) begin : g_half_top
      assign half_top = |val_i[V_W-1:M_W+1];
    end else begin : g_no_half_top
      assign half_top = 1'b0;
    end
  endgenerate

  assign half_over = half_top | (|rng_i);

  always_comb begin
    if (mode_i == CMP_HALF) mag_o = half_over ? '1 : val_i[M_W:1];
    else                    mag_o = full_over ? '1 : val_i[M_W-1:0];
  end
endmodule

// File: rtl/lut_table.sv
module lut_table #(
  parameter int AW = 12,
  parameter int DW = 6,
  parameter int HW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [HW-1:0] host_wdata_i,
  output logic [HW-1:0] host_rdata_o,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] host_q;

  always_ff @(posedge clk_i) begin
    if (host_we_i) mem[host_addr_i] <= host_wdata_i[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      host_q    <= '0;
    end else begin
      if (rd_en_i) rd_data_o <= mem[rd_addr_i];
      host_q <= mem[host_addr_i];
    end
  end

  generate
    if (HW > DW) begin : g_pad
      assign host_rdata_o = {{(HW-DW){1'b0}}, host_q};
    end else begin : g_nopad
      assign host_rdata_o = host_q;
    end
  endgenerate
endmodule

// File: rtl/miss_sig_stage.sv
module miss_sig_stage
  import miss_sig_pkg::*;
#(
  parameter int E_W  = 12,
  parameter int V_W  = 7,
  parameter int R_W  = 2,
  parameter int M_W  = 6,
  parameter int S_W  = 6,
  parameter int H_W  = 8,
  parameter int HD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [E_W-1:0]   energy_i,
  input  logic [V_W-1:0]   miss_val_i,
  input  logic [R_W-1:0]   miss_rng_i,
  input  logic             mode_i,
  output logic             valid_o,
  output logic [H_W-1:0]   hits_o,
  input  logic             host_we_i,
  input  logic             host_sel_i,
  input  logic [E_W-1:0]   host_addr_i,
  input  logic [HD_W-1:0]  host_wdata_i,
  output logic [HD_W-1:0]  host_rdata_o
);
  localparam int RA_W = M_W + S_W;

  cmp_mode_e      mode_q;
  logic [M_W-1:0] mag_d, mag_q;
  logic [S_W-1:0] root_q;
  logic           v1_q;
  logic           sel_q;
  logic [HD_W-1:0] root_host, ratio_host;
  logic [RA_W-1:0] ratio_addr;
  logic           we_root, we_ratio;

  assign we_root  = host_we_i && (host_sel_i == TBL_ROOT);
  assign we_ratio = host_we_i && (host_sel_i == TBL_RATIO);

  sig_compress #(.V_W(V_W), .R_W(R_W), .M_W(M_W)) u_cmp (
    .mode_i (mode_q),
    .val_i  (miss_val_i),
    .rng_i  (miss_rng_i),
    .mag_o  (mag_d)
  );

  lut_table #(.AW(E_W), .DW(S_W), .HW(HD_W)) u_root (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (we_root),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (root_host),
    .rd_en_i      (in_valid_i),
    .rd_addr_i    (energy_i),
    .rd_data_o    (root_q)
  );

  assign ratio_addr = {mag_q, root_q};

  lut_table #(.AW(RA_W), .DW(H_W), .HW(HD_W)) u_ratio (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (we_ratio),
    .host_addr_i  (host_addr_i[RA_W-1:0]),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (ratio_host),
    .rd_en_i      (v1_q),
    .rd_addr_i    (ratio_addr),
    .rd_data_o    (hits_o)
  );

  // stage 1 compression, stage valids, mode capture while empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q   <= '0;
      v1_q    <= 1'b0;
      valid_o <= 1'b0;
      mode_q  <= CMP_FULL;
      sel_q   <= 1'b0;
    end else begin
      if (in_valid_i) mag_q <= mag_d;
      v1_q    <= in_valid_i;
      valid_o <= v1_q;
      if (!v1_q && !valid_o) mode_q <= cmp_mode_e'(mode_i);
      sel_q   <= host_sel_i;
    end
  end

  assign host_rdata_o = sel_q ? ratio_host : root_host;

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##2 valid_o);
  a_r2_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##2 !valid_o);
  a_r10_range_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (|miss_rng_i)) |=> (mag_q == '1));
  a_r4_full_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && mode_q == CMP_FULL && miss_rng_i == '0 && !(|miss_val_i[V_W-1:M_W]))
      |=> (mag_q == $past(miss_val_i[M_W-1:0])));
  a_r7_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_q || valid_o) |=> $stable(mode_q));

  generate
    if (HD_W > S_W) begin : g_pad_chk
      a_r9_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_sel_i == TBL_ROOT) |=> (host_rdata_o[HD_W-1:S_W] == '0));
    end
  endgenerate
endmodule

// File: tb/miss_sig_stage_test.sv
module miss_sig_stage_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [11:0] energy_i = '0;
  logic [6:0]  miss_val_i = '0;
  logic [1:0]  miss_rng_i = '0;
  logic        mode_i = 1'b0;
  logic        valid_o;
  logic [7:0]  hits_o;
  logic        host_we_i = 1'b0;
  logic        host_sel_i = 1'b0;
  logic [11:0] host_addr_i = '0;
  logic [7:0]  host_wdata_i = '0;
  logic [7:0]  host_rdata_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  miss_sig_stage uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .energy_i(energy_i),
    .miss_val_i(miss_val_i), .miss_rng_i(miss_rng_i), .mode_i(mode_i),
    .valid_o(valid_o), .hits_o(hits_o), .host_we_i(host_we_i),
    .host_sel_i(host_sel_i), .host_addr_i(host_addr_i),
    .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o)
  );

  function automatic logic [5:0] root_f(int e);
    int r = 0;
    while ((r + 1) * (r + 1) <= e) r++;
    if (r > 63) r = 63;
    return 6'(r);
  endfunction

  function automatic logic [7:0] ratio_f(int a);
    int mag = a / 64;
    int rt = a % 64;
    logic [7:0] h;
    for (int t = 0; t < 8; t++) h[t] = (mag * 4 > (t + 1) * rt);
    return h;
  endfunction

  function automatic int cmp_f(bit half, int v, int r);
    if (r != 0) return 63;
    if (half) return v / 2;
    return (v > 63) ? 63 : v;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(bit sel, int a, int d);
    @(negedge clk);
    host_we_i = 1'b1; host_sel_i = sel; host_addr_i = 12'(a); host_wdata_i = 8'(d);
    @(negedge clk);
    host_we_i = 1'b0;
  endtask

  task automatic host_read(string tag, bit sel, int a, int exp);
    @(negedge clk);
    host_sel_i = sel; host_addr_i = 12'(a);
    @(negedge clk);
    check(tag, host_rdata_o, exp);
  endtask

  task automatic drive(string tag, bit half, int e, int v, int r);
    @(negedge clk);
    in_valid_i = 1'b1; energy_i = 12'(e); miss_val_i = 7'(v); miss_rng_i = 2'(r);
    exp_q.push_back(ratio_f(cmp_f(half, v, r) * 64 + root_f(e)));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid_i = 1'b0;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected valid", 1, 0);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, hits_o, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", valid_o, 0);
    check("R1 hits in reset", hits_o, 0);
    check("R1 rdata in reset", host_rdata_o, 0);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", valid_o, 0);
    check("R1 hits after reset", hits_o, 0);

    // R8 R9 padding and readback
    host_write(0, 100, 8'hFF);
    host_read("R9 root pad zero", 0, 100, 8'h3F);
    host_write(1, 77, 8'hA5);
    host_read("R9 ratio readback", 1, 77, 8'hA5);

    // R8 load tables
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      host_we_i = 1'b1; host_sel_i = 1'b0; host_addr_i = 12'(a); host_wdata_i = {2'b11, root_f(a)};
    end
    for (int a = 0; a < 4096; a++) begin
      @(negedge clk);
      host_we_i = 1'b1; host_sel_i = 1'b1; host_addr_i = 12'(a); host_wdata_i = ratio_f(a);
    end
    @(negedge clk) host_we_i = 1'b0;
    host_read("R8 root write low bits", 0, 4095, 63);
    host_read("R8 root entry", 0, 50, 7);
    host_read("R8 ratio entry", 1, 12'hFC1, ratio_f(12'hFC1));

    // full-precision mode
    mode_i = 1'b0; idle(3);
    drive("R4 small value", 0, 100, 17, 0);
    drive("R4 value 63", 0, 400, 63, 0);
    drive("R4 bit6 saturates", 0, 400, 64, 0);
    drive("R4 value 127", 0, 900, 127, 0);
    drive("R3 energy zero", 0, 0, 5, 0);
    drive("R3 energy max", 0, 4095, 40, 0);
    drive("R10 range1 full", 0, 36, 3, 1);
    drive("R10 range3 full", 0, 36, 0, 3);
    drive("R6 zero magnitude", 0, 256, 0, 0);
    idle(4);
    for (int i = 0; i < 12; i++) drive("R6 sweep full", 0, i * 331 + 7, (i * 29) % 128, 0);
    idle(4);

    // R2 isolated sample with gaps
    drive("R2 isolated", 0, 1000, 33, 0);
    idle(3);
    drive("R2 isolated", 0, 2000, 12, 0);
    idle(4);

    // R7 mode change in mid-burst is ignored
    drive("R7 burst head", 0, 625, 101, 0);
    @(negedge clk);
    mode_i = 1'b1;
    in_valid_i = 1'b1; energy_i = 12'd625; miss_val_i = 7'd101; miss_rng_i = 2'd0;
    exp_q.push_back(ratio_f(cmp_f(0, 101, 0) * 64 + root_f(625)));
    tag_q.push_back("R7 burst keeps mode");
    drive("R7 burst keeps mode", 0, 81, 45, 0);
    idle(4);

    // half-precision mode
    drive("R5 half odd value", 1, 625, 101, 0);
    drive("R5 half value 127", 1, 3000, 127, 0);
    drive("R5 half value 1", 1, 3000, 1, 0);
    drive("R5 half no bit6 sat", 1, 144, 64, 0);
    drive("R10 range2 half", 1, 144, 10, 2);
    for (int i = 0; i < 10; i++) drive("R5 sweep half", 1, i * 401 + 3, (i * 37) % 128, 0);
    idle(4);

    // back to full
    mode_i = 1'b0; idle(3);
    drive("R4 after return", 0, 49, 100, 0);
    drive("R4 after return", 0, 49, 30, 0);
    idle(5);
    check("R2 queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule